// File: doc/BRIEF.md
# Lowest-Set-Bit Execution Slice

This block is one execution slice of an integer datapath. It takes one general-purpose operand per cycle and carries out one of two operations built on its lowest set bit. The first keeps only that bit and clears every other bit. The second produces the inverted mask: every bit is one except the lowest set bit. The isolate operation also produces a full arithmetic flag bundle together with a write enable. The inverted-mask operation leaves the architectural flags alone, so it never asserts the flag write enable.

The operand size is 64 bits only when the core runs in 64-bit mode and the encoding's width bit is set. Otherwise the slice works on the low half of the operand and writes zeros into the upper result half. An encoding whose vector-length bit is set is illegal. It raises an undefined-opcode fault and produces no result and no flag write.

A parameter selects whether the outputs come straight from the combinational logic or through one pipeline register. The valid strobe travels alongside the data. While the valid output is low, every other output is held at zero.

Top module: `lsb_exec_unit`

## Requirements
- R1: With `in_op` = 0 (isolate), `out_result` equals the source ANDed with its two's-complement negation at the operand size, so only the lowest set bit stays set. A zero source gives a zero result.
- R2: With `in_op` = 1 (inverted mask), `out_result` equals the bitwise NOT of the source ORed with the source minus one at the operand size. A zero source gives all ones across the operand size.
- R3: The inverted-mask operation holds `out_flag_we` low and drives `out_flags` to zero.
- R4: For isolate, `out_flag_we` is high. `out_flags` is packed as {ZF, SF, CF, OF, AF, PF} from bit 5 down to bit 0. ZF is 1 exactly when the result is zero. SF is the result bit at position operand size minus one.
- R5: For isolate, CF is 1 when the source is nonzero at the operand size and 0 otherwise. OF, AF and PF are always driven to 0.
- R6: The operand size is 64 only when `in_mode64` and `in_w` are both 1. In every other case only source bits 31:0 take part and result bits 63:32 are zero, so `in_w` has no effect while `in_mode64` is 0.
- R7: A valid input with `in_l` = 1 sets `out_fault`, drives `out_result` and `out_flags` to zero, and holds `out_flag_we` low. `out_fault` is never set otherwise.
- R8: `out_valid` follows `in_valid` after OUT_REG cycles (default 1). While `out_valid` is low, `out_result`, `out_flags`, `out_flag_we` and `out_fault` are all zero.
- R9: During reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request this cycle |
| in_op | input | 1 | 0 = isolate lowest set bit, 1 = inverted lowest-bit mask |
| in_src | input | 64 | Source operand |
| in_mode64 | input | 1 | Core is in 64-bit mode |
| in_w | input | 1 | Encoding width bit |
| in_l | input | 1 | Encoding vector-length bit; 1 is illegal |
| out_valid | output | 1 | Result bundle valid |
| out_result | output | 64 | Operation result, zero-extended in 32-bit size |
| out_flags | output | 6 | {ZF, SF, CF, OF, AF, PF} |
| out_flag_we | output | 1 | Write the flag bundle to the architectural flags |
| out_fault | output | 1 | Undefined-opcode fault |

## Verification
On every cycle, the bound checker enforces the properties that can be seen from the outputs alone:
- an isolate result has at most one bit set;
- ZF agrees with the result, and CF is the opposite of ZF;
- the cleared flags stay at zero;
- the upper half of the result is zero in 32-bit size;
- a fault carries no result and no flag write;
- the valid strobe arrives with the correct latency, and idle outputs are zero.

The exact result value, the SF position and the fact that `in_w` is ignored outside 64-bit mode can only be shown by the bench. It sweeps every operation, every mode and width combination, and dense source patterns against an arithmetic model.

// File: rtl/lsb_pkg.sv
package lsb_pkg;

   typedef enum logic {
      LSB_OP_ISOLATE = 1'b0,
      LSB_OP_CMASK   = 1'b1
   } lsb_op_e;

   // Packed MSB first: zf lands on bit 5, pf on bit 0.
   typedef struct packed {
      logic zf;
      logic sf;
      logic cf;
      logic of;
      logic af;
      logic pf;
   } lsb_flags_t;

   localparam int LSB_FLAG_W = 6;

endpackage

// File: rtl/lsb_size_ctl.sv
module lsb_size_ctl (
   input  logic mode64,
   input  logic w_bit,
   input  logic l_bit,
   output logic wide,
   output logic illegal
);
   // W only widens the operand while the core is in 64-bit mode.
   assign wide    = mode64 & w_bit;
   assign illegal = l_bit;
endmodule

// File: rtl/lsb_core.sv
module lsb_core
   import lsb_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] src,
   input  lsb_op_e           op,
   input  logic              wide,
   output logic [DATA_W-1:0] result,
   output lsb_flags_t        flags
);
   localparam int NARROW_W = DATA_W / 2;
   localparam int N_LANES  = 2;

   logic [DATA_W-1:0] lane_res [N_LANES];
   logic              lane_nz  [N_LANES];
   logic              lane_msb [N_LANES];

   // Lane 0 works at the narrow size, lane 1 at the full size.
   for (genvar g = 0; g < N_LANES; g++) begin : g_lane
      localparam int LW = (g == 0) ? NARROW_W : DATA_W;
      logic [LW-1:0] x;
      logic [LW-1:0] iso;
      logic [LW-1:0] cmask;
      logic [LW-1:0] sel;

      assign x     = src[LW-1:0];
      assign iso   = x & (~x + LW'(1));
      assign cmask = ~x | (x - LW'(1));
      assign sel   = (op == LSB_OP_CMASK) ? cmask : iso;

      assign lane_res[g] = DATA_W'(sel);
      assign lane_nz[g]  = |x;
      assign lane_msb[g] = sel[LW-1];
   end

   always_comb begin
      result   = wide ? lane_res[1] : lane_res[0];
      flags.zf = ~|result;
      flags.sf = wide ? lane_msb[1] : lane_msb[0];
      flags.cf = wide ? lane_nz[1]  : lane_nz[0];
      flags.of = 1'b0;
      flags.af = 1'b0;
      flags.pf = 1'b0;
   end
endmodule

// File: rtl/lsb_out_stage.sv
module lsb_out_stage
   import lsb_pkg::*;
#(
   parameter int DATA_W  = 64,
   parameter int OUT_REG = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              d_valid,
   input  logic [DATA_W-1:0] d_result,
   input  lsb_flags_t        d_flags,
   input  logic              d_we,
   input  logic              d_fault,
   output logic              q_valid,
   output logic [DATA_W-1:0] q_result,
   output lsb_flags_t        q_flags,
   output logic              q_we,
   output logic              q_fault
);
   if (OUT_REG != 0) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q_valid  <= 1'b0;
            q_result <= '0;
            q_flags  <= '0;
            q_we     <= 1'b0;
            q_fault  <= 1'b0;
         end else begin
            q_valid  <= d_valid;
            q_result <= d_result;
            q_flags  <= d_flags;
            q_we     <= d_we;
            q_fault  <= d_fault;
         end
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign q_valid    = d_valid;
      assign q_result   = d_result;
      assign q_flags    = d_flags;
      assign q_we       = d_we;
      assign q_fault    = d_fault;
   end
endmodule

// File: rtl/lsb_exec_unit.sv
module lsb_exec_unit
   import lsb_pkg::*;
#(
   parameter int DATA_W  = 64,
   parameter int OUT_REG = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_op,
   input  logic [DATA_W-1:0] in_src,
   input  logic              in_mode64,
   input  logic              in_w,
   input  logic              in_l,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_result,
   output logic [5:0]        out_flags,
   output logic              out_flag_we,
   output logic              out_fault
);
   if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
      $error("lsb_exec_unit: DATA_W must be even and at least 4");
   end
   if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_reg
      $error("lsb_exec_unit: OUT_REG must be 0 or 1");
   end

   lsb_op_e           op;
   logic              wide;
   logic              illegal;
   logic [DATA_W-1:0] core_res;
   lsb_flags_t        core_flags;
   logic              ok;
   logic              isolate_ok;
   logic [DATA_W-1:0] res_g;
   lsb_flags_t        flags_g;
   logic              fault_g;
   lsb_flags_t        flags_q;

   assign op = lsb_op_e'(in_op);

   lsb_size_ctl u_size (
      .mode64  (in_mode64),
      .w_bit   (in_w),
      .l_bit   (in_l),
      .wide    (wide),
      .illegal (illegal)
   );

   lsb_core #(.DATA_W(DATA_W)) u_core (
      .src    (in_src),
      .op     (op),
      .wide   (wide),
      .result (core_res),
      .flags  (core_flags)
   );

   // Suppress everything on an idle cycle or an illegal encoding.
   assign ok         = in_valid & ~illegal;
   assign isolate_ok = ok & (op == LSB_OP_ISOLATE);
   assign res_g      = ok ? core_res : '0;
   assign flags_g    = isolate_ok ? core_flags : '0;
   assign fault_g    = in_valid & illegal;

   lsb_out_stage #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .d_valid  (in_valid),
      .d_result (res_g),
      .d_flags  (flags_g),
      .d_we     (isolate_ok),
      .d_fault  (fault_g),
      .q_valid  (out_valid),
      .q_result (out_result),
      .q_flags  (flags_q),
      .q_we     (out_flag_we),
      .q_fault  (out_fault)
   );

   assign out_flags = flags_q;
endmodule

// File: rtl/lsb_exec_checker.sv
module lsb_exec_checker #(
   parameter int DATA_W  = 64,
   parameter int OUT_REG = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_op,
   input logic              in_mode64,
   input logic              in_w,
   input logic              in_l,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_result,
   input logic [5:0]        out_flags,
   input logic              out_flag_we,
   input logic              out_fault
);
   localparam int HALF = DATA_W / 2;

   logic valid_d, op_d, wide_d, l_d;

   // Request fields aligned with the output latency.
   if (OUT_REG != 0) begin : g_lag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_d <= 1'b0;
            op_d    <= 1'b0;
            wide_d  <= 1'b0;
            l_d     <= 1'b0;
         end else begin
            valid_d <= in_valid;
            op_d    <= in_op;
            wide_d  <= in_mode64 & in_w;
            l_d     <= in_l;
         end
      end
   end else begin : g_now
      assign valid_d = in_valid;
      assign op_d    = in_op;
      assign wide_d  = in_mode64 & in_w;
      assign l_d     = in_l;
   end

   a_r3_cmask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && op_d && !out_fault) |-> (!out_flag_we && out_flags == 6'd0));

   a_r1_isolate_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
      out_flag_we |-> $onehot0(out_result));

   a_r4_zf_matches_result: assert property (@(posedge clk) disable iff (!rst_n)
      out_flag_we |-> (out_flags[5] == (out_result == '0)));

   a_r5_cf_opposes_zf: assert property (@(posedge clk) disable iff (!rst_n)
      out_flag_we |-> (out_flags[3] != out_flags[5]));

   a_r5_cleared_flags: assert property (@(posedge clk) disable iff (!rst_n)
      out_flag_we |-> (out_flags[2:0] == 3'd0));

   a_r6_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !wide_d) |-> (out_result[DATA_W-1:HALF] == '0));

   a_r7_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      out_fault |-> (out_result == '0 && !out_flag_we && out_flags == 6'd0));

   a_r7_fault_source: assert property (@(posedge clk) disable iff (!rst_n)
      out_fault == (valid_d && l_d));

   a_r8_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == valid_d);

   a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_result == '0 && out_flags == 6'd0 && !out_flag_we && !out_fault));
endmodule

bind lsb_exec_unit lsb_exec_checker #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_op       (in_op),
   .in_mode64   (in_mode64),
   .in_w        (in_w),
   .in_l        (in_l),
   .out_valid   (out_valid),
   .out_result  (out_result),
   .out_flags   (out_flags),
   .out_flag_we (out_flag_we),
   .out_fault   (out_fault)
);

// File: tb/lsb_exec_unit_test.sv
`timescale 1ns/100ps
module lsb_exec_unit_test;
   localparam int DW = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_op = 1'b0;
   logic [DW-1:0] in_src = '0;
   logic          in_mode64 = 1'b0;
   logic          in_w = 1'b0;
   logic          in_l = 1'b0;
   logic          out_valid;
   logic [DW-1:0] out_result;
   logic [5:0]    out_flags;
   logic          out_flag_we;
   logic          out_fault;

   int n_checks = 0;
   int n_bad    = 0;

   always #2.5 clk = ~clk;

   lsb_exec_unit #(.DATA_W(DW), .OUT_REG(1)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_op       (in_op),
      .in_src      (in_src),
      .in_mode64   (in_mode64),
      .in_w        (in_w),
      .in_l        (in_l),
      .out_valid   (out_valid),
      .out_result  (out_result),
      .out_flags   (out_flags),
      .out_flag_we (out_flag_we),
      .out_fault   (out_fault)
   );

   task automatic check(input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // Lowest set bit found by scanning upward from bit 0.
   function automatic logic [63:0] lowest_bit(input logic [63:0] s, input int n);
      for (int i = 0; i < n; i++)
         if (s[i]) return 64'd1 << i;
      return 64'd0;
   endfunction

   task automatic apply(input logic v, input logic op, input logic [63:0] s,
                        input logic m64, input logic w, input logic l);
      int          n;
      logic [63:0] mask, iso, exp_res;
      logic [5:0]  exp_fl;
      logic        exp_we;
      @(negedge clk);
      in_valid = v; in_op = op; in_src = s; in_mode64 = m64; in_w = w; in_l = l;
      @(posedge clk);
      #1;
      n    = (m64 && w) ? 64 : 32;
      mask = (n == 64) ? ~64'd0 : 64'h0000_0000_FFFF_FFFF;
      iso  = lowest_bit(s, n);
      check("R8", "out_valid", 64'(out_valid), 64'(v));
      if (!v) begin
         check("R8", "idle result", out_result, 64'd0);
         check("R8", "idle flags", 64'(out_flags), 64'd0);
         check("R8", "idle we", 64'(out_flag_we), 64'd0);
         check("R8", "idle fault", 64'(out_fault), 64'd0);
      end else if (l) begin
         check("R7", "fault", 64'(out_fault), 64'd1);
         check("R7", "fault result", out_result, 64'd0);
         check("R7", "fault flags", 64'(out_flags), 64'd0);
         check("R7", "fault we", 64'(out_flag_we), 64'd0);
      end else begin
         check("R7", "no fault", 64'(out_fault), 64'd0);
         if (op == 1'b0) begin
            exp_res = iso;
            check("R1", "isolate result", out_result, exp_res);
            exp_we = 1'b1;
            exp_fl = {exp_res == 64'd0, exp_res[n-1], (s & mask) != 64'd0, 3'b000};
            check("R4", "flag we", 64'(out_flag_we), 64'(exp_we));
            check("R4", "zf", 64'(out_flags[5]), 64'(exp_fl[5]));
            check("R4", "sf", 64'(out_flags[4]), 64'(exp_fl[4]));
            check("R5", "cf", 64'(out_flags[3]), 64'(exp_fl[3]));
            check("R5", "of/af/pf", 64'(out_flags[2:0]), 64'd0);
         end else begin
            exp_res = ~iso & mask;
            check("R2", "cmask result", out_result, exp_res);
            check("R3", "cmask we", 64'(out_flag_we), 64'd0);
            check("R3", "cmask flags", 64'(out_flags), 64'd0);
         end
         if (n == 32)
            check("R6", "upper half", out_result >> 32, 64'd0);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_checks++;
      n_bad++;
      $display("FAIL R8 watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R9", "reset valid", 64'(out_valid), 64'd0);
      check("R9", "reset result", out_result, 64'd0);
      check("R9", "reset flags", 64'(out_flags), 64'd0);
      check("R9", "reset we/fault", {62'd0, out_flag_we, out_fault}, 64'd0);
      rst_n = 1'b1;

      apply(1'b0, 1'b0, 64'hFFFF, 1'b1, 1'b1, 1'b0);

      for (int m = 0; m < 4; m++) begin
         for (int op = 0; op < 2; op++) begin
            for (int s = 0; s < 512; s++)
               apply(1'b1, op[0], 64'(s), m[1], m[0], 1'b0);
            for (int b = 0; b < 64; b++) begin
               apply(1'b1, op[0], 64'd1 << b, m[1], m[0], 1'b0);
               apply(1'b1, op[0], ~64'd0 << b, m[1], m[0], 1'b0);
               apply(1'b1, op[0], (64'd1 << b) | 64'hA5A5_0000_0000_0000, m[1], m[0], 1'b0);
            end
            apply(1'b1, op[0], 64'h8000_0000_0000_0000, m[1], m[0], 1'b0);
            apply(1'b1, op[0], 64'hFFFF_FFFF_0000_0000, m[1], m[0], 1'b0);
            apply(1'b1, op[0], 64'h0000_0000_8000_0000, m[1], m[0], 1'b0);
            apply(1'b1, op[0], 64'h1234_5678_9ABC_DEF0, m[1], m[0], 1'b1);
            apply(1'b1, op[0], 64'd0, m[1], m[0], 1'b1);
            apply(1'b0, op[0], 64'h0F0F, m[1], m[0], 1'b1);
         end
      end

      apply(1'b1, 1'b0, 64'h40, 1'b1, 1'b1, 1'b0);
      apply(1'b0, 1'b0, 64'h40, 1'b1, 1'b1, 1'b0);
      apply(1'b1, 1'b1, 64'd0, 1'b0, 1'b1, 1'b0);

      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end
endmodule